// File: doc/BRIEF.md
# Laser Safety Fault Latch Controller

This block is the safety gate in front of a laser transmitter's bias, modulation and peaking current DACs. It watches three fault sources. The first is a comparator flag that reports the bias monitor voltage above its reference. The second is a digital check that the measured photodiode current code has not gone beyond one and a half times its setpoint code. The third is a digital check that a new bias control code is not less than half the code it replaces. When fault detection is enabled, any of these trips a latch. The latch drops all three DAC enables and raises a fault output.

The latch survives the removal of its cause. It is cleared only when the part is held disabled long enough. Disabled means the external disable pin is high or the enable control bit is low, and the minimum hold time is a parameter. The hold timer starts again from zero whenever the disabled state is interrupted. When the part is released with no fault present, the enables return after a turn-on delay parameter, and no setting is lost. If the fault is still present at release, the fault output comes back and the currents stay off. A high disable pin or a low enable bit always turns the currents off. The peaking enable is also held low when both the overshoot height and the undershoot height settings are zero.

Top module: `laser_safety_ctrl`

## Requirements
- R1: With the fault-enable bit at 1, a high bias monitor flag sets fault_out high at the second rising clock edge after the flag is applied, and bias_en, mod_en and peak_en are all low from that point.
- R2: A photodiode fault is raised when 2×pd_meas > 3×pd_set; a measured code of exactly 150% of the setpoint raises no fault.
- R3: A bias-code update (bias_upd high for one cycle) whose code satisfies 2×new < previous updated code raises a fault; a new code of exactly half the previous one does not.
- R4: With the fault-enable bit at 0, no fault source sets fault_out or removes the enables.
- R5: Once latched, fault_out stays high and the enables stay low after every fault source has gone, for as long as the part stays enabled.
- R6: fault_out is low while the part is disabled. If the disabled state ends before RST_CYC cycles have elapsed, fault_out returns high and the enables stay low.
- R7: A disabled state held for RST_CYC cycles or more, followed by a release with no fault present, leaves fault_out low. The enables return ON_CYC cycles after the release, and not before.
- R8: If a fault source is still active when a long enough disabled state ends, fault_out re-asserts within a few cycles and the enables stay low.
- R9: enable bit 0 drops all enables in the same cycle; a high disable pin drops them after its two-flop synchronizer, regardless of fault state.
- R10: peak_en is low whenever os_height and us_height are both zero, even while bias_en is high.
- R11: After reset, fault_out and all enables are low, and the enables rise only after the turn-on delay with the part enabled.
- R12: The disabled-time counter restarts if the disabled state is interrupted, so two short disabled periods that together exceed RST_CYC do not clear a latched fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dis_pin | input | 1 | External disable pin, asynchronous, active high |
| ena_bit | input | 1 | Enable control bit, 1 = enabled |
| flt_en_bit | input | 1 | Fault detection enable bit |
| mon_over | input | 1 | Bias monitor comparator over-limit flag |
| pd_meas | input | PD_W | Measured photodiode current code |
| pd_set | input | PD_W | Photodiode current setpoint code |
| bias_code | input | CODE_W | Bias control DAC code |
| bias_upd | input | 1 | One-cycle strobe marking a new bias_code |
| os_height | input | HT_W | Overshoot height setting |
| us_height | input | HT_W | Undershoot height setting |
| bias_en | output | 1 | Bias current DAC enable |
| mod_en | output | 1 | Modulation current DAC enable |
| peak_en | output | 1 | Peaking current DAC enable |
| fault_out | output | 1 | Latched fault flag |

## Verification
The hardest state to reach is a latched fault whose disabled period is interrupted. The two pieces last long enough together but not one at a time, and the latch must survive. The stimulus gets there by toggling the disable pin in two bursts shorter than the minimum hold, with a release between them long enough to pass the synchronizer. The bias-drop check needs a known previous code. The stimulus loads that code while the part is held disabled, where a drop is ignored. It then applies random new codes near half of it once the part runs again, so that both sides of the boundary occur.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic [1:0] {
    LS_HOLD = 2'd0,
    LS_WAIT = 2'd1,
    LS_RUN  = 2'd2,
    LS_TRIP = 2'd3
  } lsc_state_e;
endpackage

// File: rtl/lsc_sync.sv
module lsc_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= {STAGES{RST_VAL}};
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/lsc_detect.sv
module lsc_detect #(
  parameter int CODE_W = 8,
  parameter int PD_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mon_over,
  input  logic [PD_W-1:0]   pd_meas,
  input  logic [PD_W-1:0]   pd_set,
  input  logic [CODE_W-1:0] bias_code,
  input  logic              bias_upd,
  output logic              flt_q
);
  localparam int PW = PD_W + 2;
  localparam int CW = CODE_W + 1;

  logic [CODE_W-1:0] prev_code, prev_code_n;
  logic [PW-1:0]     meas_x2, set_x3;
  logic [CW-1:0]     new_x2, prev_ext;
  logic              pd_hi, code_drop, flt_n;

  // integer forms of the percentage checks
  always_comb begin
    meas_x2  = {1'b0, pd_meas, 1'b0};
    set_x3   = {2'b00, pd_set} + {1'b0, pd_set, 1'b0};
    pd_hi    = meas_x2 > set_x3;
    new_x2   = {bias_code, 1'b0};
    prev_ext = {1'b0, prev_code};
    code_drop = bias_upd && (new_x2 < prev_ext);
    flt_n    = mon_over | pd_hi | code_drop;
    prev_code_n = bias_upd ? bias_code : prev_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_code <= '0;
      flt_q     <= 1'b0;
    end else begin
      prev_code <= prev_code_n;
      flt_q     <= flt_n;
    end
  end

  // previous code only moves on an update strobe (drop reference, R3)
  assert_prev_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bias_upd |=> $stable(prev_code));
endmodule

// File: rtl/lsc_fsm.sv
module lsc_fsm
  import lsc_pkg::*;
#(
  parameter int RST_CYC = 200,
  parameter int ON_CYC  = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic off_req,
  input  logic flt_q,
  input  logic flt_en,
  output logic drv_on,
  output logic fault_out
);
  localparam int MAXC  = (RST_CYC > ON_CYC) ? RST_CYC : ON_CYC;
  localparam int TMR_W = $clog2(MAXC + 1);
  localparam logic [TMR_W-1:0] RST_LIM = TMR_W'(RST_CYC - 1);
  localparam logic [TMR_W-1:0] ON_LIM  = TMR_W'(ON_CYC - 1);

  lsc_state_e       st, st_n;
  logic [TMR_W-1:0] tmr, tmr_n;
  logic             lat, lat_n;
  logic             trip;

  always_comb begin
    st_n  = st;
    tmr_n = tmr;
    lat_n = lat;
    trip  = flt_en & flt_q;
    if (off_req) begin
      if (st != LS_HOLD) begin
        st_n  = LS_HOLD;
        tmr_n = '0;
      end else begin
        if (tmr != RST_LIM) tmr_n = tmr + 1'b1;
        else                lat_n = 1'b0;
      end
    end else begin
      unique case (st)
        LS_HOLD: begin
          if (lat || trip) begin
            st_n  = LS_TRIP;
            lat_n = 1'b1;
          end else begin
            st_n  = LS_WAIT;
            tmr_n = '0;
          end
        end
        LS_WAIT: begin
          if (trip) begin
            st_n  = LS_TRIP;
            lat_n = 1'b1;
          end else if (tmr == ON_LIM) begin
            st_n = LS_RUN;
          end else begin
            tmr_n = tmr + 1'b1;
          end
        end
        LS_RUN: begin
          if (trip) begin
            st_n  = LS_TRIP;
            lat_n = 1'b1;
          end
        end
        default: st_n = LS_TRIP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= LS_HOLD;
      tmr <= '0;
      lat <= 1'b0;
    end else begin
      st  <= st_n;
      tmr <= tmr_n;
      lat <= lat_n;
    end
  end

  assign drv_on    = (st == LS_RUN) && !off_req;
  assign fault_out = (st == LS_TRIP) && !off_req;

  // qualified fault while running trips on the next edge
  assert_trip_fast_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LS_RUN && !off_req && flt_q && flt_en) |=> (st == LS_TRIP));

  // latched fault persists while enabled
  assert_latch_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LS_TRIP && !off_req) |=> (st == LS_TRIP));

  // release with the latch still set returns to the fault state
  assert_short_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LS_HOLD && lat && !off_req) |=> (st == LS_TRIP));

  // faults ignored with detection disabled
  assert_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LS_RUN && !off_req && !flt_en) |=> (st == LS_RUN));
endmodule

// File: rtl/laser_safety_ctrl.sv
module laser_safety_ctrl #(
  parameter int CODE_W      = 8,
  parameter int PD_W        = 10,
  parameter int HT_W        = 4,
  parameter int SYNC_STAGES = 2,
  parameter int RST_CYC     = 200,
  parameter int ON_CYC      = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dis_pin,
  input  logic              ena_bit,
  input  logic              flt_en_bit,
  input  logic              mon_over,
  input  logic [PD_W-1:0]   pd_meas,
  input  logic [PD_W-1:0]   pd_set,
  input  logic [CODE_W-1:0] bias_code,
  input  logic              bias_upd,
  input  logic [HT_W-1:0]   os_height,
  input  logic [HT_W-1:0]   us_height,
  output logic              bias_en,
  output logic              mod_en,
  output logic              peak_en,
  output logic              fault_out
);
  logic dis_s, off_req, flt_q, drv_on, shape_nz;

  lsc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(dis_pin), .q(dis_s)
  );

  lsc_detect #(.CODE_W(CODE_W), .PD_W(PD_W)) u_det (
    .clk(clk), .rst_n(rst_n), .mon_over(mon_over), .pd_meas(pd_meas),
    .pd_set(pd_set), .bias_code(bias_code), .bias_upd(bias_upd), .flt_q(flt_q)
  );

  assign off_req = dis_s | ~ena_bit;

  lsc_fsm #(.RST_CYC(RST_CYC), .ON_CYC(ON_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .off_req(off_req), .flt_q(flt_q),
    .flt_en(flt_en_bit), .drv_on(drv_on), .fault_out(fault_out)
  );

  assign shape_nz = (|os_height) | (|us_height);
  assign bias_en  = drv_on;
  assign mod_en   = drv_on;
  assign peak_en  = drv_on & shape_nz;

  assert_ena_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ena_bit |-> (!bias_en && !mod_en && !peak_en));

  assert_peak_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (os_height == '0 && us_height == '0) |-> !peak_en);

  assert_fault_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fault_out |-> (!bias_en && !mod_en && !peak_en));
endmodule

// File: tb/laser_safety_ctrl_bench.sv
module laser_safety_ctrl_bench;
  localparam int CODE_W = 8;
  localparam int PD_W   = 10;
  localparam int HT_W   = 4;
  localparam int RST_C  = 16;
  localparam int ON_C   = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic dis_pin, ena_bit, flt_en_bit, mon_over, bias_upd;
  logic [PD_W-1:0]   pd_meas, pd_set;
  logic [CODE_W-1:0] bias_code;
  logic [HT_W-1:0]   os_height, us_height;
  logic bias_en, mod_en, peak_en, fault_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  laser_safety_ctrl #(
    .CODE_W(CODE_W), .PD_W(PD_W), .HT_W(HT_W), .SYNC_STAGES(2),
    .RST_CYC(RST_C), .ON_CYC(ON_C)
  ) u_laser_safety_ctrl (
    .clk(clk), .rst_n(rst_n), .dis_pin(dis_pin), .ena_bit(ena_bit),
    .flt_en_bit(flt_en_bit), .mon_over(mon_over), .pd_meas(pd_meas),
    .pd_set(pd_set), .bias_code(bias_code), .bias_upd(bias_upd),
    .os_height(os_height), .us_height(us_height), .bias_en(bias_en),
    .mod_en(mod_en), .peak_en(peak_en), .fault_out(fault_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit pd_expect(input int meas, input int setp);
    return (2 * meas) > (3 * setp);
  endfunction

  function automatic bit drop_expect(input int nw, input int old);
    return (2 * nw) < old;
  endfunction

  task automatic upd(input int code);
    bias_code = CODE_W'(code);
    bias_upd  = 1'b1;
    cyc(1);
    bias_upd  = 1'b0;
  endtask

  // long disabled period with benign sources; loads a reference bias code
  task automatic recover(input int ref_code);
    mon_over = 1'b0;
    pd_meas  = '0;
    dis_pin  = 1'b1;
    cyc(4);
    upd(ref_code);
    cyc(RST_C + 4);
    dis_pin = 1'b0;
    cyc(ON_C + 8);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; dis_pin = 1'b0; ena_bit = 1'b1; flt_en_bit = 1'b1;
    mon_over = 1'b0; pd_meas = '0; pd_set = 10'd100; bias_code = '0;
    bias_upd = 1'b0; os_height = 4'd3; us_height = 4'd0;
    cyc(3);
    rst_n = 1'b1;
    #1;
    check("R11 reset bias_en", bias_en, 0);
    check("R11 reset fault_out", fault_out, 0);
    cyc(4);
    check("R11 early bias_en", bias_en, 0);
    cyc(ON_C + 8);
    check("R11 bias_en up", bias_en, 1);
    check("R11 peak_en up", peak_en, 1);

    // R1 monitor flag, two edges
    mon_over = 1'b1;
    cyc(1);
    check("R1 one edge fault_out", fault_out, 0);
    cyc(1);
    check("R1 fault_out", fault_out, 1);
    check("R1 bias_en", bias_en, 0);
    check("R1 mod_en", mod_en, 0);
    check("R1 peak_en", peak_en, 0);
    // R5 latch survives removal
    mon_over = 1'b0;
    cyc(10);
    check("R5 latched fault_out", fault_out, 1);
    check("R5 bias_en", bias_en, 0);
    // R6 short hold
    dis_pin = 1'b1;
    cyc(4);
    check("R6 fault_out while disabled", fault_out, 0);
    cyc(4);
    dis_pin = 1'b0;
    cyc(5);
    check("R6 fault_out after short hold", fault_out, 1);
    check("R6 bias_en", bias_en, 0);
    // R12 interrupted holds
    dis_pin = 1'b1; cyc(RST_C - 4);
    dis_pin = 1'b0; cyc(3);
    dis_pin = 1'b1; cyc(RST_C - 4);
    dis_pin = 1'b0; cyc(5);
    check("R12 fault_out kept", fault_out, 1);
    // R7 long hold, clean release
    dis_pin = 1'b1;
    cyc(RST_C + 6);
    dis_pin = 1'b0;
    cyc(4);
    check("R7 fault_out cleared", fault_out, 0);
    check("R7 bias_en delayed", bias_en, 0);
    cyc(10);
    check("R7 bias_en back", bias_en, 1);
    // R8 fault present on release
    mon_over = 1'b1;
    cyc(3);
    dis_pin = 1'b1;
    cyc(RST_C + 6);
    dis_pin = 1'b0;
    cyc(5);
    check("R8 fault_out reasserted", fault_out, 1);
    check("R8 bias_en", bias_en, 0);
    recover(0);
    check("R8 recovered", bias_en, 1);
    // R9 enable bit and pin
    ena_bit = 1'b0;
    #1;
    check("R9 ena off bias_en", bias_en, 0);
    check("R9 ena off mod_en", mod_en, 0);
    cyc(2);
    ena_bit = 1'b1;
    cyc(ON_C + 6);
    check("R9 ena back", bias_en, 1);
    dis_pin = 1'b1;
    cyc(2);
    check("R9 pin off mod_en", mod_en, 0);
    dis_pin = 1'b0;
    cyc(ON_C + 6);
    check("R9 pin back", mod_en, 1);
    // R10 peaking heights
    os_height = '0; us_height = '0;
    #1;
    check("R10 peak_en zero heights", peak_en, 0);
    check("R10 bias_en", bias_en, 1);
    us_height = 4'd5;
    #1;
    check("R10 peak_en undershoot", peak_en, 1);
    // R4 detection disabled
    flt_en_bit = 1'b0;
    mon_over = 1'b1;
    pd_meas = 10'd1000;
    cyc(5);
    check("R4 fault_out", fault_out, 0);
    check("R4 bias_en", bias_en, 1);
    mon_over = 1'b0; pd_meas = '0;
    cyc(2);
    flt_en_bit = 1'b1;
    cyc(3);
    check("R4 still running", bias_en, 1);
    // R2 boundary
    pd_set = 10'd100; pd_meas = 10'd150;
    cyc(4);
    check("R2 exactly 150pct", fault_out, 0);
    pd_meas = 10'd151;
    cyc(2);
    check("R2 above 150pct", fault_out, 1);
    recover(200);
    // R3 boundary
    upd(100);
    cyc(3);
    check("R3 exactly half", fault_out, 0);
    upd(49);
    cyc(2);
    check("R3 below half", fault_out, 1);
    recover(0);

    // random photodiode trials (R2)
    for (int i = 0; i < 25; i++) begin
      int s, m;
      bit e;
      s = $urandom % 512;
      m = (i % 2 == 0) ? ($urandom % 1024) : ((3 * s) / 2 + ($urandom % 3));
      if (m > 1023) m = 1023;
      e = pd_expect(m, s);
      pd_set = PD_W'(s); pd_meas = PD_W'(m);
      cyc(3);
      check("R2 random pd", fault_out, e);
      pd_meas = '0;
      if (e) recover(0);
    end
    // random bias drop trials (R3)
    for (int i = 0; i < 25; i++) begin
      int a, b;
      bit e;
      a = 8 + ($urandom % 248);
      b = a / 2 + int'($urandom % 5) - 2;
      recover(a);
      e = drop_expect(b, a);
      upd(b);
      cyc(2);
      check("R3 random drop", fault_out, e);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule